// File: doc/BRIEF.md
# Associative Address Lookup Table

This block is a binary content-addressable table for layer-2 address translation. Each stored word is 64 bits wide and carries its own validity flag. A host reaches the block over a 32-bit data bus. It builds a 64-bit key by loading a low half and a high half, then issues a command. On a search, the key is compared against every valid word at once, and the index of the lowest matching word is returned one cycle later. That index is returned on a result bus that is separate from the host data bus, so it can drive the address of an external RAM holding port data.

Table maintenance uses the same result bus. A write stores the key in the lowest free slot, and a delete removes a word either by index or by match. Each of these operations reports the affected index, so the external RAM can be updated in the same step.

Several devices can be chained. A device reports a hit only when no device upstream has already hit. Writes go to the first device that is not full. Match and full status are merged along the chain. The first device in a chain ties `up_hit` low and `up_full` high.

Top module: `cam_lookup`

## Requirements
- R1: After reset every slot is invalid, `full` is low and `res_valid` is low, so a search of any key misses.
- R2: Opcode 1 loads `host_data` as key bits 31:0 and opcode 2 loads it as key bits 63:32. A search compares all 64 key bits, so a key that differs from a stored word only in its high half misses.
- R3: Opcode 3 (search) raises `res_valid` exactly one cycle after the command, whatever the fill level and whatever the position of the match. `res_hit` and `res_index` report the outcome.
- R4: Only valid slots take part in a comparison, so a deleted word no longer matches.
- R5: When several valid words match, the lowest index is reported. On a miss, `res_hit` is low and `res_index` is 0.
- R6: Opcode 4 (write) stores the key in the lowest-numbered invalid slot, sets that slot valid, and reports the slot with `res_hit` high.
- R7: `full` is high when every slot is valid. A write while full leaves the table unchanged and reports `res_hit` low.
- R8: Opcode 5 clears the validity of slot `cmd_index` and reports that index with `res_hit` high.
- R9: Opcode 6 clears the validity of the lowest valid slot matching the key and reports its index. If nothing matches, it reports `res_hit` low.
- R10: Opcode 7 sets the validity of slot `cmd_index`, so the word stored there matches again. The index is reported.
- R11: Opcode 8 places word `cmd_index` on `rd_data` one cycle later: bits 63:32 when `cmd_upper` is 1, and bits 31:0 otherwise.
- R12: Opcode 9 clears every validity flag in one command.
- R13: In a chain, `up_hit` high suppresses a search hit (`res_hit` low, `res_index` 0). `dn_hit` is the OR of `up_hit` and the local search hit. `up_full` low blocks writes, and `dn_full` is high only when both `up_full` and `full` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Opcode (see requirements) |
| cmd_upper | input | 1 | Half select for reads |
| cmd_index | input | IDX_W | Slot index for indexed commands |
| host_data | input | 32 | Key half being loaded |
| up_hit | input | 1 | Upstream device reports a hit |
| up_full | input | 1 | All upstream devices are full |
| res_valid | output | 1 | Result bus holds a new result |
| res_hit | output | 1 | Result reports a found or affected slot |
| res_index | output | IDX_W | Reported slot index |
| rd_data | output | 32 | Read half-word |
| full | output | 1 | No invalid slot remains |
| dn_hit | output | 1 | Chain match to the next device |
| dn_full | output | 1 | Chain full to the next device |

## Verification
Search is tried with four key patterns:
- A key held only once, which checks that the correct index is found.
- A key that differs from a stored word only in its upper half, which shows whether both halves are compared.
- A key stored at two indices, which separates lowest-index priority from any other choice.
- A key whose only copy has been deleted, which shows whether validity gates the comparison.

Writes are driven until the table is full and then once more, which separates the free-slot search from overwriting. The cascade inputs are toggled around a hit, which shows whether gating and status merging follow the chain inputs.

// File: rtl/cam_pkg.sv
`timescale 1ns/1ps
package cam_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_KEY_LO  = 4'd1,
    OP_KEY_HI  = 4'd2,
    OP_SEARCH  = 4'd3,
    OP_WRITE   = 4'd4,
    OP_DEL_IDX = 4'd5,
    OP_DEL_KEY = 4'd6,
    OP_SET_IDX = 4'd7,
    OP_READ    = 4'd8,
    OP_INIT    = 4'd9
  } cam_op_e;

  localparam int HALF_W = 32;
  localparam int WORD_W = 2 * HALF_W;
endpackage

// File: rtl/cam_prio_enc.sv
`timescale 1ns/1ps
module cam_prio_enc #(
  parameter int N = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = i[IW-1:0];
    end
  end
endmodule

// File: rtl/cam_array.sv
`timescale 1ns/1ps
module cam_array #(
  parameter int DEPTH = 64,
  parameter int W     = 64,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [W-1:0]     wr_word,
  input  logic             set_en,
  input  logic [IW-1:0]    set_idx,
  input  logic             clr_en,
  input  logic [IW-1:0]    clr_idx,
  input  logic             init_en,
  input  logic [W-1:0]     key,
  input  logic [IW-1:0]    rd_idx,
  output logic [W-1:0]     rd_word,
  output logic [DEPTH-1:0] valid_vec,
  output logic [DEPTH-1:0] match_vec
);
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst || init_en) begin
      valid_q <= '0;
    end else begin
      if (wr_en)  valid_q[wr_idx]  <= 1'b1;
      if (set_en) valid_q[set_idx] <= 1'b1;
      if (clr_en) valid_q[clr_idx] <= 1'b0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g] && (mem[g] == key);
  end

  assign valid_vec = valid_q;
  assign rd_word   = mem[rd_idx];
endmodule

// File: rtl/cam_lookup.sv
`timescale 1ns/1ps
module cam_lookup #(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic             cmd_upper,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [31:0]      host_data,
  input  logic             up_hit,
  input  logic             up_full,
  output logic             res_valid,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_index,
  output logic [31:0]      rd_data,
  output logic             full,
  output logic             dn_hit,
  output logic             dn_full
);
  import cam_pkg::*;

  logic [HALF_W-1:0] key_lo_q, key_hi_q;
  logic [WORD_W-1:0] key, rd_word;
  logic [DEPTH-1:0]  valid_vec, match_vec;
  logic              hit_found, free_found;
  logic [IDX_W-1:0]  hit_idx, free_idx;
  logic              is_op_write, is_op_set, is_op_del_idx, is_op_del_key, is_op_init;
  logic              wr_ok, clr_en;
  logic [IDX_W-1:0]  clr_idx;
  logic              hit_q, search_q, gate;
  logic [IDX_W-1:0]  idx_q;

  assign key = {key_hi_q, key_lo_q};

  assign is_op_write   = cmd_valid && (cmd_op == OP_WRITE);
  assign is_op_set     = cmd_valid && (cmd_op == OP_SET_IDX);
  assign is_op_del_idx = cmd_valid && (cmd_op == OP_DEL_IDX);
  assign is_op_del_key = cmd_valid && (cmd_op == OP_DEL_KEY);
  assign is_op_init    = cmd_valid && (cmd_op == OP_INIT);

  assign wr_ok   = is_op_write && free_found && up_full;
  assign clr_en  = is_op_del_idx || (is_op_del_key && hit_found);
  assign clr_idx = is_op_del_idx ? cmd_index : hit_idx;

  cam_array #(.DEPTH(DEPTH), .W(WORD_W)) u_array (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_ok),
    .wr_idx   (free_idx),
    .wr_word  (key),
    .set_en   (is_op_set),
    .set_idx  (cmd_index),
    .clr_en   (clr_en),
    .clr_idx  (clr_idx),
    .init_en  (is_op_init),
    .key      (key),
    .rd_idx   (cmd_index),
    .rd_word  (rd_word),
    .valid_vec(valid_vec),
    .match_vec(match_vec)
  );

  cam_prio_enc #(.N(DEPTH)) u_hit_enc (
    .req  (match_vec),
    .found(hit_found),
    .idx  (hit_idx)
  );

  cam_prio_enc #(.N(DEPTH)) u_free_enc (
    .req  (~valid_vec),
    .found(free_found),
    .idx  (free_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      key_lo_q  <= '0;
      key_hi_q  <= '0;
      res_valid <= 1'b0;
      hit_q     <= 1'b0;
      idx_q     <= '0;
      search_q  <= 1'b0;
      rd_data   <= '0;
    end else begin
      res_valid <= 1'b0;
      search_q  <= 1'b0;
      if (cmd_valid) begin
        case (cmd_op)
          OP_KEY_LO: key_lo_q <= host_data;
          OP_KEY_HI: key_hi_q <= host_data;
          OP_SEARCH: begin
            res_valid <= 1'b1;
            search_q  <= 1'b1;
            hit_q     <= hit_found;
            idx_q     <= hit_found ? hit_idx : '0;
          end
          OP_DEL_KEY: begin
            res_valid <= 1'b1;
            hit_q     <= hit_found;
            idx_q     <= hit_found ? hit_idx : '0;
          end
          OP_WRITE: begin
            res_valid <= 1'b1;
            hit_q     <= wr_ok;
            idx_q     <= wr_ok ? free_idx : '0;
          end
          OP_DEL_IDX, OP_SET_IDX: begin
            res_valid <= 1'b1;
            hit_q     <= 1'b1;
            idx_q     <= cmd_index;
          end
          OP_READ: rd_data <= cmd_upper ? rd_word[WORD_W-1:HALF_W] : rd_word[HALF_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign gate      = search_q && up_hit;
  assign res_hit   = hit_q && !gate;
  assign res_index = gate ? '0 : idx_q;
  assign full      = !free_found;
  assign dn_full   = full && up_full;
  assign dn_hit    = up_hit || (search_q && hit_q);
endmodule

// File: rtl/cam_lookup_chk.sv
`timescale 1ns/1ps
module cam_lookup_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [3:0]       cmd_op,
  input logic [IDX_W-1:0] cmd_index,
  input logic             up_hit,
  input logic             up_full,
  input logic             full,
  input logic             res_valid,
  input logic             res_hit,
  input logic [IDX_W-1:0] res_index
);
  import cam_pkg::*;

  assert_search_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_SEARCH) |=> res_valid);

  assert_miss_index_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_index == '0));

  assert_write_lands_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_WRITE && !full && up_full) |=> (res_valid && res_hit));

  assert_write_full_dropped_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_WRITE && (full || !up_full)) |=> (res_valid && !res_hit));

  assert_del_reports_index_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_DEL_IDX) |=> (res_hit && res_index == $past(cmd_index)));

  assert_init_empties_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_INIT) |=> !full);

  assert_chain_gate_R13: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_valid && cmd_op == OP_SEARCH) && up_hit) |-> !res_hit);
endmodule

bind cam_lookup cam_lookup_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .cmd_op   (cmd_op),
  .cmd_index(cmd_index),
  .up_hit   (up_hit),
  .up_full  (up_full),
  .full     (full),
  .res_valid(res_valid),
  .res_hit  (res_hit),
  .res_index(res_index)
);

// File: tb/cam_lookup_test.sv
`timescale 1ns/1ps
module cam_lookup_test;
  localparam int DEPTH = 8;
  localparam int IW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [3:0]    cmd_op = '0;
  logic          cmd_upper = 1'b0;
  logic [IW-1:0] cmd_index = '0;
  logic [31:0]   host_data = '0;
  logic          up_hit = 1'b0;
  logic          up_full = 1'b1;
  logic          res_valid, res_hit, full, dn_hit, dn_full;
  logic [IW-1:0] res_index;
  logic [31:0]   rd_data;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  cam_lookup #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_upper(cmd_upper), .cmd_index(cmd_index), .host_data(host_data),
    .up_hit(up_hit), .up_full(up_full), .res_valid(res_valid),
    .res_hit(res_hit), .res_index(res_index), .rd_data(rd_data),
    .full(full), .dn_hit(dn_hit), .dn_full(dn_full)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] d,
                       input int idx, input logic up);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; host_data = d;
    cmd_index = idx[IW-1:0]; cmd_upper = up;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
  endtask

  task automatic load(input logic [63:0] k);
    issue(4'd1, k[31:0], 0, 1'b0);
    issue(4'd2, k[63:32], 0, 1'b0);
  endtask

  task automatic search(input string req, input logic [63:0] k,
                        input bit exp_hit, input int exp_idx);
    load(k);
    issue(4'd3, '0, 0, 1'b0);
    check({req, " valid"}, res_valid, 1);
    check({req, " hit"}, res_hit, exp_hit);
    check({req, " index"}, res_index, exp_hit ? exp_idx : 0);
  endtask

  task automatic write(input string req, input logic [63:0] k,
                       input bit exp_hit, input int exp_idx);
    load(k);
    issue(4'd4, '0, 0, 1'b0);
    check({req, " write hit"}, res_hit, exp_hit);
    check({req, " write index"}, res_index, exp_hit ? exp_idx : 0);
  endtask

  localparam logic [63:0] KA = 64'h1111_2222_3333_4444;
  localparam logic [63:0] KB = 64'hAAAA_0001_BEEF_0002;
  localparam logic [63:0] KC = 64'h0000_0007_0000_0009;

  task automatic t_reset();
    check("R1 full", full, 0);
    check("R1 res_valid", res_valid, 0);
    search("R1 empty search", 64'h0, 0, 0);
  endtask

  task automatic t_write_search();
    write("R6 first", KA, 1, 0);
    write("R6 second", KB, 1, 1);
    write("R6 third", KC, 1, 2);
    search("R3 middle", KB, 1, 1);
    search("R3 last", KC, 1, 2);
    search("R2 high half differs", {KB[63:32] ^ 32'h1, KB[31:0]}, 0, 0);
    search("R2 low half differs", {KB[63:32], KB[31:0] ^ 32'h1}, 0, 0);
  endtask

  task automatic t_priority_delete();
    write("R6 duplicate", KA, 1, 3);
    search("R5 lowest of two", KA, 1, 0);
    issue(4'd5, '0, 0, 1'b0);
    check("R8 del hit", res_hit, 1);
    check("R8 del index", res_index, 0);
    search("R4 deleted skipped", KA, 1, 3);
    load(KA);
    issue(4'd6, '0, 0, 1'b0);
    check("R9 del key hit", res_hit, 1);
    check("R9 del key index", res_index, 3);
    search("R4 both gone", KA, 0, 0);
    issue(4'd6, '0, 0, 1'b0);
    check("R9 del key miss", res_hit, 0);
    check("R9 del key miss index", res_index, 0);
  endtask

  task automatic t_refill_setvalid_read();
    write("R6 reuse lowest", 64'h5, 1, 0);
    issue(4'd7, '0, 3, 1'b0);
    check("R10 set hit", res_hit, 1);
    check("R10 set index", res_index, 3);
    search("R10 revived", KA, 1, 3);
    issue(4'd8, '0, 1, 1'b1);
    check("R11 read upper", rd_data, KB[63:32]);
    issue(4'd8, '0, 1, 1'b0);
    check("R11 read lower", rd_data, KB[31:0]);
  endtask

  task automatic t_full();
    for (int i = 4; i < DEPTH; i++) write("R7 fill", 64'h100 + i, 1, i);
    check("R7 full high", full, 1);
    write("R7 write while full", 64'hDEAD, 0, 0);
    search("R7 dropped key absent", 64'hDEAD, 0, 0);
    search("R7 old entry kept", KC, 1, 2);
  endtask

  task automatic t_init();
    issue(4'd9, '0, 0, 1'b0);
    check("R12 full low", full, 0);
    search("R12 cleared", KB, 0, 0);
    write("R12 restart at zero", KB, 1, 0);
  endtask

  task automatic t_chain();
    up_hit = 1'b1;
    search("R13 upstream hit gates", KB, 0, 0);
    check("R13 dn_hit passes", dn_hit, 1);
    up_hit = 1'b0;
    search("R13 local hit", KB, 1, 0);
    check("R13 dn_hit local", dn_hit, 1);
    search("R13 local miss", KC, 0, 0);
    check("R13 dn_hit low", dn_hit, 0);
    up_full = 1'b0;
    check("R13 dn_full low", dn_full, 0);
    write("R13 upstream not full", KC, 0, 0);
    search("R13 blocked write absent", KC, 0, 0);
    up_full = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_search();
    t_priority_delete();
    t_refill_setvalid_read();
    t_full();
    t_init();
    t_chain();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule